// File: doc/BRIEF.md
# Register-File Serial Slave with Change Interrupt

This block is a two-wire serial (I2C-compatible, standard mode) slave that gives a host byte-wide access to a 256-entry address space. A write transaction carries a memory address and then any number of data bytes, which land at consecutive locations. A read transaction streams bytes from the current pointer, moving up one location per byte until the host answers with a NACK. When a transaction ends, the pointer returns to the last memory address the host sent, so the same location can be polled again and again without a new address phase.

Two status bytes are driven from surrounding logic: a key-detection byte and an input-line byte. An active-low change line falls when an enabled status bit moves, and it rises again under read rules set out below. A fixed window after reset refuses the slave address. A stuck-bus watchdog returns the bus logic to idle when a line sits low and frozen for too long, unless standalone operation is selected. Writing a nonzero value to either of two command locations raises a one-cycle strobe.

Top module: `i2c_reg_slave`

## Requirements
- R1: A first byte whose upper seven bits equal 0x12 is acknowledged (bit 0 = 1 selects a read, 0 a write); every other seven-bit address is not acknowledged.
- R2: For INIT_CYCLES clock cycles after reset, the slave address is not acknowledged.
- R3: In a write, the first byte after the address sets the memory address and each further byte is stored at the next location; locations 8 to NREGS-1 are storage, and byte k of `regs_o` (bits 8k+7..8k) holds location k.
- R4: A read returns the byte at the pointer and moves the pointer up by one per byte, continuing after each host ACK and stopping at a host NACK.
- R5: After any STOP, the pointer returns to the last memory address written by the host.
- R6: Location 0 reads {calibrating, 0, keys[5:0]}, location 1 reads {0, inputs[6:0]}; locations 2 to 7 and NREGS and up read zero and ignore writes; writes to 0 and 1 are ignored; the pointer wraps from 255 to 0.
- R7: Writing a nonzero byte to location 12 pulses `cal_stb_o` for one cycle, and to location 13 pulses `rst_stb_o`; a zero write pulses nothing.
- R8: `chg_n_o` goes low after a change of any input line, or of a detection bit enabled by the enable byte at location 16 (bits 5..0 enable keys, bit 7 enables the calibrating bit); changes of disabled bits leave it high.
- R9: A read of location 0 or 1 releases `chg_n_o` and records the status as seen; a read of any other location releases it only when the enabled status equals that recorded value.
- R10: When SCL or SDA stays low with neither line changing for STUCK_CYCLES cycles, the bus logic returns to idle and releases SDA; with `standalone_i` high this never happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| standalone_i | input | 1 | Disables the stuck-bus watchdog |
| det_i | input | NKEYS | Key detection status |
| cal_i | input | 1 | Calibration in progress flag |
| in_i | input | NINS | Input line status |
| regs_o | output | NREGS*8 | Register file contents, location k at bits 8k+7..8k |
| cal_stb_o | output | 1 | Calibration command strobe |
| rst_stb_o | output | 1 | Reset command strobe |
| chg_n_o | output | 1 | Active-low change indication |

## Verification
The hardest state to reach is the release rule for the change line when the status has flipped and then flipped back before any read, since it depends on the snapshot taken at the previous status read rather than on anything visible at the pins. The bench reaches it by first reading the status bytes to fix the snapshot, toggling an input line away and back, then reading an ordinary storage location; it repeats the same read with the line left changed to show the line stays low, and only a status read then frees it. The watchdog is reached by stalling SCL low in the middle of a read byte whose current bit is zero, so that the slave is visibly holding SDA until the timer fires.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    L_IDLE,
    L_ADDR,
    L_AACK,
    L_WBYTE,
    L_WACK,
    L_RBYTE,
    L_RACK
  } link_state_t;
endpackage

// File: rtl/i2cs_pads.sv
module i2cs_pads (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/i2cs_guard.sv
module i2cs_guard #(
  parameter int INIT_CYCLES  = 480000,
  parameter int STUCK_CYCLES = 224000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic standalone_i,
  output logic init_busy_o,
  output logic clr_o
);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int SW = $clog2(STUCK_CYCLES + 1);
  localparam logic [IW-1:0] INIT_END = IW'(INIT_CYCLES);
  localparam logic [SW-1:0] STUCK_END = SW'(STUCK_CYCLES - 1);

  logic [IW-1:0] icnt_q, icnt_n;
  logic [SW-1:0] wcnt_q, wcnt_n;
  logic          scl_p, sda_p, stuck;

  assign init_busy_o = (icnt_q != INIT_END);
  assign stuck = (!scl_s_i || !sda_s_i) && (scl_s_i == scl_p) && (sda_s_i == sda_p)
                 && !standalone_i;
  assign clr_o = stuck && (wcnt_q == STUCK_END);

  always_comb begin
    icnt_n = init_busy_o ? icnt_q + 1'b1 : icnt_q;
    if (!stuck)     wcnt_n = '0;
    else if (clr_o) wcnt_n = '0;
    else            wcnt_n = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
      wcnt_q <= '0;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      icnt_q <= icnt_n;
      wcnt_q <= wcnt_n;
      scl_p  <= scl_s_i;
      sda_p  <= sda_s_i;
    end
  end

  // R10: after a clear the timer restarts, so clears never come back to back
  assert_clear_spaced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !clr_o);
endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
  import i2cs_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       init_busy_i,
  input  logic [7:0] tx_byte_i,
  output logic       sda_oe_o,
  output logic       wr_vld_o,
  output logic       wr_first_o,
  output logic [7:0] wr_data_o,
  output logic       rd_take_o
);
  link_state_t st_q, st_n;
  logic [3:0]  cnt_q, cnt_n;
  logic [7:0]  sh_q, sh_n, tx_q, tx_n;
  logic        oe_q, oe_n, rw_q, rw_n, first_q, first_n;

  assign sda_oe_o   = oe_q;
  assign wr_data_o  = sh_q;
  assign wr_first_o = first_q;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; tx_n = tx_q;
    oe_n = oe_q; rw_n = rw_q; first_n = first_q;
    wr_vld_o = 1'b0; rd_take_o = 1'b0;
    if (clr_i || stop_i) begin
      st_n = L_IDLE; oe_n = 1'b0;
    end else if (start_i) begin
      st_n = L_ADDR; cnt_n = '0; oe_n = 1'b0;
    end else begin
      case (st_q)
        L_ADDR: begin
          if (scl_rise_i && cnt_q != 4'd8) begin
            sh_n = {sh_q[6:0], sda_i}; cnt_n = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            if (sh_q[7:1] == SLAVE_ADDR && !init_busy_i) begin
              oe_n = 1'b1; rw_n = sh_q[0]; st_n = L_AACK;
            end else begin
              st_n = L_IDLE;
            end
          end
        end
        L_AACK: if (scl_fall_i) begin
          cnt_n = '0;
          if (rw_q) begin
            rd_take_o = 1'b1; tx_n = tx_byte_i; oe_n = ~tx_byte_i[7]; st_n = L_RBYTE;
          end else begin
            oe_n = 1'b0; first_n = 1'b1; st_n = L_WBYTE;
          end
        end
        L_WBYTE: begin
          if (scl_rise_i && cnt_q != 4'd8) begin
            sh_n = {sh_q[6:0], sda_i}; cnt_n = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            wr_vld_o = 1'b1; first_n = 1'b0; oe_n = 1'b1; st_n = L_WACK;
          end
        end
        L_WACK: if (scl_fall_i) begin
          oe_n = 1'b0; cnt_n = '0; st_n = L_WBYTE;
        end
        L_RBYTE: begin
          if (scl_rise_i) cnt_n = cnt_q + 1'b1;
          else if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              oe_n = 1'b0; st_n = L_RACK;
            end else begin
              tx_n = {tx_q[6:0], 1'b0}; oe_n = ~tx_q[6];
            end
          end
        end
        L_RACK: begin
          if (scl_rise_i) begin
            if (sda_i) st_n = L_IDLE;
            else       cnt_n = '0;
          end else if (scl_fall_i && cnt_q == 4'd0) begin
            rd_take_o = 1'b1; tx_n = tx_byte_i; oe_n = ~tx_byte_i[7]; st_n = L_RBYTE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= L_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0;
      oe_q <= 1'b0; rw_q <= 1'b0; first_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; tx_q <= tx_n;
      oe_q <= oe_n; rw_q <= rw_n; first_q <= first_n;
    end
  end

  // R1: the acknowledge phase is entered only for the own address
  assert_ack_own_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_AACK) |-> (sh_q[7:1] == SLAVE_ADDR));
  // R2: no address acknowledge while the start-up window is open
  assert_no_ack_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy_i |-> (st_q != L_AACK));
  // R4: SDA drive only moves after SCL falls or a bus event
  assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall_i || stop_i || start_i || clr_i));
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
  parameter int NREGS = 32,
  parameter int NKEYS = 6,
  parameter int NINS  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld_i,
  input  logic             wr_first_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_take_i,
  input  logic             txn_end_i,
  input  logic [NKEYS-1:0] det_i,
  input  logic             cal_i,
  input  logic [NINS-1:0]  in_i,
  output logic [7:0]       rd_data_o,
  output logic [NREGS*8-1:0] regs_o,
  output logic             cal_stb_o,
  output logic             rst_stb_o,
  output logic             chg_n_o
);
  localparam int IW = $clog2(NREGS);
  localparam logic [7:0] DET_ADDR = 8'd0;
  localparam logic [7:0] IN_ADDR  = 8'd1;
  localparam logic [7:0] RO_TOP   = 8'd8;
  localparam logic [7:0] CAL_ADDR = 8'd12;
  localparam logic [7:0] RST_ADDR = 8'd13;
  localparam logic [7:0] KEN_ADDR = 8'd16;
  localparam logic [8:0] TOP9     = 9'(NREGS);
  localparam logic [7:0] KEYBITS  = 8'((1 << NKEYS) - 1);

  logic [7:0] mem [NREGS];
  logic [7:0] ptr_q, ptr_n, base_q, base_n;
  logic [7:0] det_byte, in_byte, det_prev, in_prev, det_ref, in_ref, en_mask;
  logic       in_store, mem_we, status_rd, ev, reverted;
  logic       pend_q, pend_n, cal_n, rst_n_stb;

  assign det_byte = {cal_i, {(7-NKEYS){1'b0}}, det_i};
  assign in_byte  = {{(8-NINS){1'b0}}, in_i};
  assign en_mask  = mem[KEN_ADDR[IW-1:0]] & (KEYBITS | 8'h80);
  assign in_store = (ptr_q >= RO_TOP) && ({1'b0, ptr_q} < TOP9);
  assign mem_we   = wr_vld_i && !wr_first_i && in_store;

  always_comb begin
    if (ptr_q == DET_ADDR)     rd_data_o = det_byte;
    else if (ptr_q == IN_ADDR) rd_data_o = in_byte;
    else if (in_store)         rd_data_o = mem[ptr_q[IW-1:0]];
    else                       rd_data_o = 8'h00;
  end

  always_comb begin
    ptr_n = ptr_q; base_n = base_q;
    if (txn_end_i) ptr_n = base_q;
    else if (wr_vld_i && wr_first_i) begin
      base_n = wr_data_i; ptr_n = wr_data_i;
    end else if (wr_vld_i || rd_take_i) ptr_n = ptr_q + 8'd1;
    cal_n     = mem_we && ptr_q == CAL_ADDR && wr_data_i != 8'h00;
    rst_n_stb = mem_we && ptr_q == RST_ADDR && wr_data_i != 8'h00;
    status_rd = rd_take_i && (ptr_q == DET_ADDR || ptr_q == IN_ADDR);
    ev        = (((det_byte ^ det_prev) & en_mask) != 8'h00) || (in_byte != in_prev);
    reverted  = (((det_byte ^ det_ref) & en_mask) == 8'h00) && (in_byte == in_ref);
    if (ev)                                   pend_n = 1'b1;
    else if (rd_take_i && (status_rd || reverted)) pend_n = 1'b0;
    else                                      pend_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= 8'h00;
    end else if (mem_we) begin
      mem[ptr_q[IW-1:0]] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0; base_q <= '0; pend_q <= 1'b0;
      det_prev <= '0; in_prev <= '0; det_ref <= '0; in_ref <= '0;
      cal_stb_o <= 1'b0; rst_stb_o <= 1'b0;
    end else begin
      ptr_q <= ptr_n; base_q <= base_n; pend_q <= pend_n;
      det_prev <= det_byte; in_prev <= in_byte;
      cal_stb_o <= cal_n; rst_stb_o <= rst_n_stb;
      if (status_rd) begin
        det_ref <= det_byte; in_ref <= in_byte;
      end
    end
  end

  for (genvar k = 0; k < NREGS; k++) begin : g_out
    assign regs_o[8*k +: 8] = mem[k];
  end
  assign chg_n_o = ~pend_q;

  // R8: an input line change always pulls the change line low next cycle
  assert_input_change_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_i != $past(in_i)) |=> !chg_n_o);
  // R9: the change line is only released following a byte read
  assert_release_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_n_o) |-> $past(rd_take_i));
  // R7: a command strobe follows a nonzero data byte
  assert_strobe_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_stb_o || rst_stb_o) |-> $past(wr_vld_i && !wr_first_i && wr_data_i != 8'h00));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int NREGS        = 32,
  parameter int NKEYS        = 6,
  parameter int NINS         = 7,
  parameter int INIT_CYCLES  = 480000,
  parameter int STUCK_CYCLES = 224000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               standalone_i,
  input  logic [NKEYS-1:0]   det_i,
  input  logic               cal_i,
  input  logic [NINS-1:0]    in_i,
  output logic [NREGS*8-1:0] regs_o,
  output logic               cal_stb_o,
  output logic               rst_stb_o,
  output logic               chg_n_o
);
  localparam logic [6:0] OWN_ADDR = 7'h12;

  logic [1:0] rst_q;
  logic       rst_s;
  logic       scl_s, sda_s, rise, fall, start, stop, init_busy, clr;
  logic       wr_vld, wr_first, rd_take;
  logic [7:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  i2cs_pads i_pads (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  i2cs_guard #(.INIT_CYCLES(INIT_CYCLES), .STUCK_CYCLES(STUCK_CYCLES)) i_guard (
    .clk(clk), .rst_n(rst_s), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .standalone_i(standalone_i), .init_busy_o(init_busy), .clr_o(clr)
  );

  i2cs_link #(.SLAVE_ADDR(OWN_ADDR)) i_link (
    .clk(clk), .rst_n(rst_s), .clr_i(clr), .sda_i(sda_s),
    .scl_rise_i(rise), .scl_fall_i(fall), .start_i(start), .stop_i(stop),
    .init_busy_i(init_busy), .tx_byte_i(rd_data), .sda_oe_o(sda_oe_o),
    .wr_vld_o(wr_vld), .wr_first_o(wr_first), .wr_data_o(wr_data),
    .rd_take_o(rd_take)
  );

  i2cs_regs #(.NREGS(NREGS), .NKEYS(NKEYS), .NINS(NINS)) i_regs (
    .clk(clk), .rst_n(rst_s), .wr_vld_i(wr_vld), .wr_first_i(wr_first),
    .wr_data_i(wr_data), .rd_take_i(rd_take), .txn_end_i(stop | clr),
    .det_i(det_i), .cal_i(cal_i), .in_i(in_i), .rd_data_o(rd_data),
    .regs_o(regs_o), .cal_stb_o(cal_stb_o), .rst_stb_o(rst_stb_o),
    .chg_n_o(chg_n_o)
  );
endmodule

// File: tb/test_i2c_reg_slave.sv
`timescale 1ns/1ps
module test_i2c_reg_slave;
  localparam int NREGS = 32;
  localparam int Q = 8;
  localparam int INIT = 2000;
  localparam int STUCK = 1000;

  logic clk = 1'b0;
  logic rst_n;
  logic h_scl, h_sda, sda_w, sda_oe, standalone;
  logic [5:0] det;
  logic cal;
  logic [6:0] inp;
  logic [NREGS*8-1:0] regs;
  logic cal_stb, rst_stb, chg_n;

  int tests = 0, fails = 0, cal_cnt = 0, rst_cnt = 0;
  bit done = 0;
  bit last_ack;
  logic [7:0] wbuf [0:31];
  logic [7:0] rbuf [0:31];
  logic [7:0] mdl [0:255];

  always #2.5 clk = ~clk;
  assign sda_w = h_sda & ~sda_oe;

  i2c_reg_slave #(.NREGS(NREGS), .INIT_CYCLES(INIT), .STUCK_CYCLES(STUCK)) i_i2c_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(h_scl), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .standalone_i(standalone), .det_i(det), .cal_i(cal), .in_i(inp),
    .regs_o(regs), .cal_stb_o(cal_stb), .rst_stb_o(rst_stb), .chg_n_o(chg_n)
  );

  always @(negedge clk) begin
    if (cal_stb) cal_cnt++;
    if (rst_stb) rst_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart(); h_sda = 1; h_scl = 1; w(Q); h_sda = 0; w(Q); h_scl = 0; w(Q); endtask
  task automatic bstop();  h_sda = 0; w(Q); h_scl = 1; w(Q); h_sda = 1; w(2*Q); endtask
  task automatic sbit(input bit b); h_sda = b; w(Q); h_scl = 1; w(2*Q); h_scl = 0; w(Q); endtask
  task automatic rbit(output bit b);
    h_sda = 1; w(Q); h_scl = 1; w(Q); b = sda_w; w(Q); h_scl = 0; w(Q);
  endtask
  task automatic sbyte(input logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    rbit(b); last_ack = !b;
  endtask
  task automatic rbyte(output logic [7:0] d, input bit last);
    bit b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    sbit(last);
  endtask

  function automatic logic [7:0] expv(input logic [7:0] a);
    if (a == 8'd0) return {cal, 1'b0, det};
    if (a == 8'd1) return {1'b0, inp};
    if (a >= 8 && a < NREGS) return mdl[a];
    return 8'h00;
  endfunction

  task automatic wr_seq(input logic [7:0] a, input int n);
    bstart(); sbyte(8'h24); sbyte(a);
    for (int i = 0; i < n; i++) begin
      sbyte(wbuf[i]);
      if (8'(a + i) >= 8 && 8'(a + i) < NREGS) mdl[8'(a + i)] = wbuf[i];
    end
    bstop();
  endtask
  task automatic set_ptr(input logic [7:0] a); wr_seq(a, 0); endtask
  task automatic rd_seq(input int n);
    bstart(); sbyte(8'h25);
    for (int i = 0; i < n; i++) rbyte(rbuf[i], i == n - 1);
    bstop();
  endtask

  initial begin
    rst_n = 0; h_scl = 1; h_sda = 1; standalone = 0; det = '0; cal = 0; inp = '0;
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    w(10); rst_n = 1; w(4);
    chk(chg_n == 1'b1, "R8 change line idle after reset", chg_n, 1);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
    chk(regs == '0, "R3 register file clear after reset", regs[31:0], 0);

    // R2: address refused inside the start-up window
    bstart(); sbyte(8'h24); bstop();
    chk(!last_ack, "R2 address NACK during init", last_ack, 0);
    w(INIT);

    // R1: sweep of every seven-bit address
    for (int a = 0; a < 128; a++) begin
      bstart(); sbyte({7'(a), 1'b0}); bstop();
      chk(last_ack == (a == 'h12), $sformatf("R1 address %0h ack", a), last_ack, a == 'h12);
    end

    // R3 / R4: burst write of the whole storage region, burst readback
    for (int i = 0; i < NREGS - 8; i++) wbuf[i] = 8'(i * 37 + 5);
    wr_seq(8'd8, NREGS - 8);
    for (int k = 0; k < NREGS; k++)
      chk(regs[8*k +: 8] == mdl[k], $sformatf("R3 regs_o byte %0d", k), regs[8*k +: 8], mdl[k]);
    set_ptr(8'd8); rd_seq(NREGS - 8);
    for (int i = 0; i < NREGS - 8; i++)
      chk(rbuf[i] == mdl[8 + i], $sformatf("R4 burst read %0d", 8 + i), rbuf[i], mdl[8 + i]);

    // R6: read-only and unbacked locations ignore writes
    det = 6'h15; inp = 7'h33;
    wbuf[0] = 8'hFF; wr_seq(8'd3, 1); wr_seq(8'd40, 1); wr_seq(8'd0, 1);
    for (int a = 0; a < 36; a++) begin
      set_ptr(8'(a)); rd_seq(1);
      chk(rbuf[0] == expv(8'(a)), $sformatf("R6 single read %0d", a), rbuf[0], expv(8'(a)));
    end

    // R6: pointer wraps from 255 to 0
    det = 6'h2A; cal = 1; inp = 7'h55;
    set_ptr(8'd255); rd_seq(3);
    chk(rbuf[0] == 8'h00, "R6 wrap byte 255", rbuf[0], 0);
    chk(rbuf[1] == 8'hAA, "R6 wrap byte 0", rbuf[1], 8'hAA);
    chk(rbuf[2] == 8'h55, "R6 wrap byte 1", rbuf[2], 8'h55);
    cal = 0;

    // R5: pointer returns to the host address after each transaction
    set_ptr(8'd20); rd_seq(3); rd_seq(3);
    for (int i = 0; i < 3; i++)
      chk(rbuf[i] == mdl[20 + i], "R5 repeat read from same address", rbuf[i], mdl[20 + i]);
    wbuf[0] = 8'h6C; wbuf[1] = 8'h93; wr_seq(8'd10, 2); rd_seq(1);
    chk(rbuf[0] == 8'h6C, "R5 read after write returns to base", rbuf[0], 8'h6C);

    // R7: command strobes
    cal_cnt = 0; rst_cnt = 0;
    wbuf[0] = 8'h01; wr_seq(8'd12, 1);
    chk(cal_cnt == 1, "R7 nonzero calibrate write", cal_cnt, 1);
    wbuf[0] = 8'h00; wr_seq(8'd12, 1);
    chk(cal_cnt == 1, "R7 zero calibrate write", cal_cnt, 1);
    wbuf[0] = 8'h80; wr_seq(8'd13, 1);
    chk(rst_cnt == 1, "R7 nonzero reset write", rst_cnt, 1);
    wbuf[0] = 8'h03; wbuf[1] = 8'h00; wr_seq(8'd12, 2);
    chk(cal_cnt == 2 && rst_cnt == 1, "R7 burst across both commands", cal_cnt*16 + rst_cnt, 8'h21);

    // R8 / R9: change line
    set_ptr(8'd0); rd_seq(2);
    chk(chg_n == 1'b1, "R9 status read releases", chg_n, 1);
    wbuf[0] = 8'h01; wr_seq(8'd16, 1);
    det[1] = ~det[1]; w(10);
    chk(chg_n == 1'b1, "R8 disabled key ignored", chg_n, 1);
    det[0] = ~det[0]; w(10);
    chk(chg_n == 1'b0, "R8 enabled key change", chg_n, 0);
    set_ptr(8'd0); rd_seq(1);
    chk(chg_n == 1'b1, "R9 detection byte read releases", chg_n, 1);
    inp[3] = ~inp[3]; w(10);
    chk(chg_n == 1'b0, "R8 input change", chg_n, 0);
    inp[3] = ~inp[3]; w(10);
    chk(chg_n == 1'b0, "R8 reverted input keeps line low", chg_n, 0);
    set_ptr(8'd8); rd_seq(1);
    chk(chg_n == 1'b1, "R9 any read releases after revert", chg_n, 1);
    inp[4] = ~inp[4]; w(10);
    set_ptr(8'd8); rd_seq(1);
    chk(chg_n == 1'b0, "R9 other read holds when not reverted", chg_n, 0);
    set_ptr(8'd1); rd_seq(1);
    chk(chg_n == 1'b1, "R9 input byte read releases", chg_n, 1);
    cal = 1; w(10);
    chk(chg_n == 1'b1, "R8 calibrating bit disabled", chg_n, 1);
    wbuf[0] = 8'h81; wr_seq(8'd16, 1);
    cal = 0; w(10);
    chk(chg_n == 1'b0, "R8 calibrating bit enabled", chg_n, 0);

    // R10: stuck-bus watchdog
    set_ptr(8'd2);
    bstart(); sbyte(8'h25); w(100);
    chk(sda_oe == 1'b1, "R10 slave driving before timeout", sda_oe, 1);
    w(STUCK + 50);
    chk(sda_oe == 1'b0, "R10 released after timeout", sda_oe, 0);
    bstop();
    standalone = 1;
    bstart(); sbyte(8'h25); w(STUCK + 50);
    chk(sda_oe == 1'b1, "R10 standalone keeps watchdog off", sda_oe, 1);
    standalone = 0; w(STUCK + 50);
    chk(sda_oe == 1'b0, "R10 watchdog active again", sda_oe, 0);
    bstop(); w(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired before the sequence completed");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule